// File: doc/BRIEF.md
# Multiframe Maintenance Message Channel

This block carries the two slow maintenance channels of a multiframe link layer. The first channel has a low-priority and a high-priority transmit register. The second channel has one transmit register. Each channel moves one 4-bit message per multiframe: one bit per maintenance slot, four slots per multiframe, 800 b/s per channel. A controller loads the transmit messages and the configuration through a small write port. At each multiframe start the block latches the word to send, then presents it bit by bit on the slot strobes.

On receive, the block collects four slot bits per channel into a word. It accepts that word either at once or only after three identical words in consecutive multiframes. It raises a one-cycle interrupt when the accepted word changes. It also produces a pulse on every multiframe start (5 ms) and on every sixth one (30 ms), each with its own enable. Frame alignment and line coding are handled elsewhere. The block only sees the multiframe-start pulse, the slot strobe and the slot bits.

Top module: `mf_maint_chan`

## Requirements
- R1: After reset both transmit bits are 1, both accepted messages are 1111, all interrupt outputs are 0, every write register is 0, and the 30 ms phase counter is 0.
- R2: The transmitted word is latched at `mf_start`. At the k-th `slot_stb` after that (k = 0..3), the transmit bit is word bit 3-k, so the most significant bit goes first. Before the first `mf_start` and after the fourth slot, the transmit bit is 1.
- R3: A write to the high-priority register (address 1) marks it pending. At the next `mf_start`, channel 1 latches the pending high word in place of the low word (address 0) and clears the pending mark. Later multiframes send the low word again.
- R4: Channel 2 latches its own register (address 2) at every `mf_start`. A write in the same cycle as `mf_start` takes effect at the following multiframe start; this holds for all three message registers.
- R5: Control register (address 3) holds enables in bits 0 and 1 for channels 1 and 2, and 3x validation in bit 2. A disabled channel drives 1 on its transmit bit and ignores its receive bit, so its accepted message and receive interrupt do not change.
- R6: With 3x validation off, a word formed from four slot bits of one multiframe is accepted as soon as its fourth bit arrives. The first received bit is the most significant.
- R7: With 3x validation on, a word is accepted once it has been received in three consecutive completions. A different word restarts the count at one with itself as candidate.
- R8: An acceptance changes `rx_msgN` and pulses `irq_rxN` for one cycle only when the word differs from the previously accepted one. The update and pulse appear in the cycle after the fourth slot.
- R9: An `mf_start` arriving before four slots discards the partial word. A `slot_stb` in the same cycle as `mf_start`, or beyond the fourth slot, is ignored.
- R10: With bit 0 of the interrupt-enable register (address 4) set, `irq_mf` pulses for one cycle after each `mf_start`.
- R11: With bit 1 of address 4 set, `irq_6mf` pulses for one cycle after every sixth `mf_start` counted from reset. The count advances whether or not the pulse is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mf_start | input | 1 | Multiframe start pulse |
| slot_stb | input | 1 | Maintenance slot strobe, shared by both channels |
| rx_bit1 | input | 1 | Received slot bit, channel 1 |
| rx_bit2 | input | 1 | Received slot bit, channel 2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 4 | Register write data |
| tx_bit1 | output | 1 | Transmit slot bit, channel 1 |
| tx_bit2 | output | 1 | Transmit slot bit, channel 2 |
| rx_msg1 | output | 4 | Accepted message, channel 1 |
| rx_msg2 | output | 4 | Accepted message, channel 2 |
| irq_rx1 | output | 1 | New accepted message pulse, channel 1 |
| irq_rx2 | output | 1 | New accepted message pulse, channel 2 |
| irq_mf | output | 1 | Per-multiframe pulse |
| irq_6mf | output | 1 | Every-sixth-multiframe pulse |

## Verification
The checker watches several properties on every cycle:
- a receive interrupt always comes with a change of the accepted message and follows a slot strobe;
- both timer pulses follow a multiframe start;
- a disabled channel's accepted message stays frozen.

Only the bench's scenarios show the following:
- the bit order on the slots;
- the one-shot preference for the high-priority word;
- the three-in-a-row rule with its restart on a different word;
- partial-word discard;
- the six-multiframe phase.

The bench's cycle model compares every output on each clock for these.

// File: rtl/mf_maint_chan.sv
module mf_maint_chan #(
  parameter int MSG_W    = 4,
  parameter int MF_GROUP = 6,
  parameter int AW       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mf_start,
  input  logic             slot_stb,
  input  logic             rx_bit1,
  input  logic             rx_bit2,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [MSG_W-1:0] wr_data,
  output logic             tx_bit1,
  output logic             tx_bit2,
  output logic [MSG_W-1:0] rx_msg1,
  output logic [MSG_W-1:0] rx_msg2,
  output logic             irq_rx1,
  output logic             irq_rx2,
  output logic             irq_mf,
  output logic             irq_6mf
);
  localparam int IW = $clog2(MSG_W + 1);
  localparam int GW = $clog2(MF_GROUP);
  localparam logic [IW-1:0] IDX_LAST = IW'(MSG_W - 1);
  localparam logic [IW-1:0] IDX_IDLE = IW'(MSG_W);
  localparam logic [GW-1:0] GRP_LAST = GW'(MF_GROUP - 1);
  localparam logic [AW-1:0] A_LO  = AW'(0);
  localparam logic [AW-1:0] A_HI  = AW'(1);
  localparam logic [AW-1:0] A_SC2 = AW'(2);
  localparam logic [AW-1:0] A_CTL = AW'(3);
  localparam logic [AW-1:0] A_IE  = AW'(4);

  logic [MSG_W-1:0] lo_msg, hi_msg, sc2_msg;
  logic             hi_pend;
  logic [1:0]       en;
  logic             v3x, ie5, ie30;
  logic [1:0][MSG_W-1:0] cur;
  logic [IW-1:0]    idx;
  logic [GW-1:0]    grp;
  logic [IW-1:0]    bsel;
  logic             slot_ok;
  logic [1:0]       rxb, txb, irq_rx;
  logic [1:0][MSG_W-1:0] acc;

  assign bsel    = IDX_LAST - idx;
  assign slot_ok = slot_stb && !mf_start && (idx != IDX_IDLE);
  assign rxb     = {rx_bit2, rx_bit1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_msg  <= '0;
      hi_msg  <= '0;
      sc2_msg <= '0;
      hi_pend <= 1'b0;
      en      <= '0;
      v3x     <= 1'b0;
      ie5     <= 1'b0;
      ie30    <= 1'b0;
      cur     <= '0;
      idx     <= IDX_IDLE;
      grp     <= '0;
      irq_mf  <= 1'b0;
      irq_6mf <= 1'b0;
    end else begin
      irq_mf  <= 1'b0;
      irq_6mf <= 1'b0;
      if (mf_start) begin
        idx     <= '0;
        cur[0]  <= hi_pend ? hi_msg : lo_msg;
        cur[1]  <= sc2_msg;
        hi_pend <= 1'b0;
        irq_mf  <= ie5;
        if (grp == GRP_LAST) begin
          grp     <= '0;
          irq_6mf <= ie30;
        end else begin
          grp <= grp + 1'b1;
        end
      end else if (slot_ok) begin
        idx <= idx + 1'b1;
      end
      if (wr_en) begin
        case (wr_addr)
          A_LO:  lo_msg <= wr_data;
          A_HI: begin
            hi_msg  <= wr_data;
            hi_pend <= 1'b1;
          end
          A_SC2: sc2_msg <= wr_data;
          A_CTL: begin
            en  <= wr_data[1:0];
            v3x <= wr_data[2];
          end
          A_IE: begin
            ie5  <= wr_data[0];
            ie30 <= wr_data[1];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [MSG_W-1:0] sh, cand, word;
    logic [1:0]       cnt, cnt_nx;
    logic             done, accept;

    assign txb[ch] = (en[ch] && idx != IDX_IDLE) ? cur[ch][bsel] : 1'b1;
    assign word    = {sh[MSG_W-2:0], rxb[ch]};
    assign done    = slot_ok && en[ch] && (idx == IDX_LAST);
    assign cnt_nx  = (word != cand) ? 2'd1 : (cnt == 2'd3) ? 2'd3 : cnt + 2'd1;
    assign accept  = !v3x || (cnt_nx == 2'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh         <= '0;
        cand       <= '1;
        cnt        <= '0;
        acc[ch]    <= '1;
        irq_rx[ch] <= 1'b0;
      end else begin
        irq_rx[ch] <= 1'b0;
        if (slot_ok && en[ch]) sh <= word;
        if (done) begin
          cand <= word;
          cnt  <= cnt_nx;
          if (accept && word != acc[ch]) begin
            acc[ch]    <= word;
            irq_rx[ch] <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_bit1 = txb[0];
  assign tx_bit2 = txb[1];
  assign rx_msg1 = acc[0];
  assign rx_msg2 = acc[1];
  assign irq_rx1 = irq_rx[0];
  assign irq_rx2 = irq_rx[1];
endmodule

module mf_maint_chan_chk #(
  parameter int MSG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mf_start,
  input logic             slot_stb,
  input logic [1:0]       en,
  input logic [MSG_W-1:0] rx_msg1,
  input logic [MSG_W-1:0] rx_msg2,
  input logic             irq_rx1,
  input logic             irq_rx2,
  input logic             irq_mf,
  input logic             irq_6mf
);
  p_irq_change1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx1 |-> rx_msg1 != $past(rx_msg1));
  p_irq_change2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx2 |-> rx_msg2 != $past(rx_msg2));
  p_irq_after_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx1 || irq_rx2) |-> $past(slot_stb) && !$past(mf_start));
  p_frozen_off1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |=> $stable(rx_msg1));
  p_frozen_off2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |=> $stable(rx_msg2));
  p_mf_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mf |-> $past(mf_start));
  p_grp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_6mf |-> $past(mf_start));
endmodule

bind mf_maint_chan mf_maint_chan_chk #(.MSG_W(MSG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .slot_stb(slot_stb), .en(en),
  .rx_msg1(rx_msg1), .rx_msg2(rx_msg2), .irq_rx1(irq_rx1), .irq_rx2(irq_rx2),
  .irq_mf(irq_mf), .irq_6mf(irq_6mf)
);

// File: tb/sim_mf_maint_chan.sv
module sim_mf_maint_chan;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mf_start = 1'b0, slot_stb = 1'b0, rx_bit1 = 1'b1, rx_bit2 = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic tx_bit1, tx_bit2, irq_rx1, irq_rx2, irq_mf, irq_6mf;
  logic [3:0] rx_msg1, rx_msg2;

  int vectors = 0, fails = 0;
  bit started = 0;

  always #(PERIOD/2) clk = ~clk;

  mf_maint_chan u0 (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .slot_stb(slot_stb),
    .rx_bit1(rx_bit1), .rx_bit2(rx_bit2), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_bit1(tx_bit1), .tx_bit2(tx_bit2), .rx_msg1(rx_msg1),
    .rx_msg2(rx_msg2), .irq_rx1(irq_rx1), .irq_rx2(irq_rx2), .irq_mf(irq_mf),
    .irq_6mf(irq_6mf)
  );

  // reference model
  logic [3:0] m_lo = 0, m_hi = 0, m_sc2 = 0, m_cur1 = 0, m_cur2 = 0;
  bit m_hip = 0, m_en1 = 0, m_en2 = 0, m_v3 = 0, m_ie5 = 0, m_ie30 = 0;
  int m_pos = 4, m_grp = 0;
  bit q1[$], q2[$];
  logic [3:0] m_cand[2] = '{4'hF, 4'hF};
  logic [3:0] m_acc[2]  = '{4'hF, 4'hF};
  int m_cnt[2] = '{0, 0};
  bit e_irq[2] = '{0, 0};
  bit e_mf = 0, e_6mf = 0;

  task automatic take_word(int ch, logic [3:0] w);
    if (w == m_cand[ch]) m_cnt[ch] = (m_cnt[ch] >= 3) ? 3 : m_cnt[ch] + 1;
    else begin m_cand[ch] = w; m_cnt[ch] = 1; end
    if ((!m_v3 || m_cnt[ch] == 3) && w != m_acc[ch]) begin
      m_acc[ch] = w;
      e_irq[ch] = 1;
    end
  endtask

  always @(posedge clk) begin
    started <= 1;
    e_irq[0] = 0; e_irq[1] = 0; e_mf = 0; e_6mf = 0;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_sc2 = 0; m_cur1 = 0; m_cur2 = 0; m_hip = 0;
      m_en1 = 0; m_en2 = 0; m_v3 = 0; m_ie5 = 0; m_ie30 = 0; m_pos = 4; m_grp = 0;
      q1.delete(); q2.delete();
      m_cand = '{4'hF, 4'hF}; m_acc = '{4'hF, 4'hF}; m_cnt = '{0, 0};
    end else begin
      if (mf_start) begin
        q1.delete(); q2.delete();
        m_pos = 0;
        m_cur1 = m_hip ? m_hi : m_lo;
        m_hip = 0;
        m_cur2 = m_sc2;
        e_mf = m_ie5;
        m_grp++;
        if (m_grp == 6) begin m_grp = 0; e_6mf = m_ie30; end
      end else if (slot_stb && m_pos < 4) begin
        m_pos++;
        if (m_en1) begin
          q1.push_back(rx_bit1);
          if (q1.size() == 4) begin take_word(0, {q1[0], q1[1], q1[2], q1[3]}); q1.delete(); end
        end
        if (m_en2) begin
          q2.push_back(rx_bit2);
          if (q2.size() == 4) begin take_word(1, {q2[0], q2[1], q2[2], q2[3]}); q2.delete(); end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_lo = wr_data;
          3'd1: begin m_hi = wr_data; m_hip = 1; end
          3'd2: m_sc2 = wr_data;
          3'd3: begin m_en1 = wr_data[0]; m_en2 = wr_data[1]; m_v3 = wr_data[2]; end
          3'd4: begin m_ie5 = wr_data[0]; m_ie30 = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string nm, string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    cmp("tx_bit1", "R2/R3", int'(tx_bit1), (m_en1 && m_pos < 4) ? int'(m_cur1[3-m_pos]) : 1);
    cmp("tx_bit2", "R2/R4", int'(tx_bit2), (m_en2 && m_pos < 4) ? int'(m_cur2[3-m_pos]) : 1);
    cmp("rx_msg1", "R6/R7", int'(rx_msg1), int'(m_acc[0]));
    cmp("rx_msg2", "R6/R7", int'(rx_msg2), int'(m_acc[1]));
    cmp("irq_rx1", "R8", int'(irq_rx1), int'(e_irq[0]));
    cmp("irq_rx2", "R8", int'(irq_rx2), int'(e_irq[1]));
    cmp("irq_mf", "R10", int'(irq_mf), int'(e_mf));
    cmp("irq_6mf", "R11", int'(irq_6mf), int'(e_6mf));
  end

  task automatic step(bit mf, bit sl, bit r1, bit r2);
    @(negedge clk); #1;
    mf_start = mf; slot_stb = sl; rx_bit1 = r1; rx_bit2 = r2; wr_en = 0;
  endtask

  task automatic wr(int a, int d, bit mf = 0);
    @(negedge clk); #1;
    mf_start = mf; slot_stb = 0; wr_en = 1; wr_addr = 3'(a); wr_data = 4'(d);
  endtask

  task automatic frame(logic [3:0] a, logic [3:0] b, int n = 4, bit do_mf = 1);
    if (do_mf) step(1, 0, 0, 0);
    for (int k = 0; k < n; k++) begin
      step(0, 0, !a[3-k], !b[3-k]);
      step(0, 1, a[3-k], b[3-k]);
    end
    step(0, 0, 1, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;                      // R1 reset values checked by model
    step(0, 0, 0, 0);
    frame(4'h6, 4'h9);                 // R5 channels disabled: bits ignored
    wr(0, 4'hA); wr(2, 4'h5); wr(3, 3); wr(4, 1);
    frame(4'h6, 4'h9);                 // R2 R4 R6 R10
    frame(4'h6, 4'h9);                 // R8 same word: no interrupt
    frame(4'hC, 4'h3);
    wr(1, 4'h3);                       // R3 high priority once
    frame(4'h1, 4'h2);
    frame(4'h1, 4'h2);
    wr(1, 4'h7, 1);                    // R4 write coincident with mf_start
    frame(4'hE, 4'h0, 4, 0);
    frame(4'hE, 4'h0);
    frame(4'h5, 4'h5, 2);              // R9 partial word discarded
    frame(4'h8, 4'h4, 6);              // R9 extra slots ignored
    wr(3, 7);                          // R7 3x validation
    frame(4'hC, 4'hC); frame(4'hC, 4'hC); frame(4'h3, 4'hC);
    frame(4'hC, 4'hC); frame(4'hC, 4'hC); frame(4'hC, 4'h0);
    frame(4'hC, 4'h0); frame(4'hC, 4'h0);
    wr(3, 6);                          // R5 channel 1 off
    frame(4'h0, 4'hF); frame(4'h0, 4'hF); frame(4'h0, 4'hF);
    wr(4, 2);                          // R11 every sixth frame
    for (int i = 0; i < 13; i++) frame(4'(i), 4'(i + 3));
    wr(4, 3); wr(3, 3);
    for (int i = 0; i < 7; i++) frame(4'(i * 5), 4'(i * 3));
    repeat (4) step(0, 0, 0, 0);
    finish_run();
  end
endmodule